// File: doc/BRIEF.md
# Pending Interrupt Register with Mask

This block collects interrupt events from outside the chip into a 16-bit pending register. Seven active-low user request lines are watched for a falling transition. Each such transition sets the pending bit of its line, and the bit stays set until software clears it. A separate active-low power-fail line sets the top pending bit for as long as it is held low.

A mask register decides which user pending bits may raise the single interrupt request output. Setting a mask bit blocks its line. The power-fail bit ignores the mask and always raises the request. Software reads both registers, writes the mask, and clears pending bits by writing ones to a clear port. An active-low master reset returns the whole block to its idle state.

All external request lines pass through a two-flop synchronizer before anything acts on them. A user bit is therefore set on the third rising clock edge after its line falls. The power-fail bit follows the same latency.

Top module: `irq_pending_ctrl`

## Requirements
- R1: While master reset is low and after it is released, pending_o and mask_o read 16'h0000 and irq_o is low.
- R2: A high-to-low transition on user_irq_n[i] (i = 0..6) sets pending_o[i] on the third rising clock edge after the transition. Holding the line low, or returning it high, does not set the bit again.
- R3: A mask write stores mask_wr_data bits 0..6, and mask bits 7..15 always read 0. A set mask bit does not stop its pending bit from latching.
- R4: irq_o is high exactly when some pending bit among 0..6 has a clear mask bit, or when pending bit 15 is set.
- R5: While the synchronized power_fail_n is low, pending_o[15] is set and cannot be cleared. irq_o is then high whatever the mask holds.
- R6: When clr_en is high, each pending bit with a 1 in clr_data is cleared on the next rising edge. Bits with a 0 in clr_data keep their value.
- R7: If a clear of bit i and a new detected falling transition on line i happen in the same cycle, pending_o[i] stays set.
- R8: Pending bits 7..14 always read 0, and clear writes to them have no effect.
- R9: Pulling master reset low for one clock period clears all pending bits and the mask, even when both held set bits beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| user_irq_n | input | 7 | User request lines, falling transition counts as an event |
| power_fail_n | input | 1 | Power-fail line, active low, level sensitive |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 16 | Mask write value, 1 blocks a line |
| clr_en | input | 1 | Pending clear strobe |
| clr_data | input | 16 | Write-one-to-clear pattern for pending bits |
| pending_o | output | 16 | Pending register read value |
| mask_o | output | 16 | Mask register read value |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that every request line stays at each level long enough for the two-flop synchronizer to see it. They also assume that software strobes are single-cycle, synchronous pulses. The bench drives all inputs on the falling clock edge and holds every line level for at least three cycles, so no transition is lost or seen twice. Same-cycle set and clear is produced on purpose, by timing the clear strobe to the cycle in which the synchronized falling transition reaches the pending register.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
   localparam int unsigned DEF_REG_W       = 16;
   localparam int unsigned DEF_NUM_USER    = 7;
   localparam int unsigned DEF_PF_BIT      = 15;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // mask of register positions that belong to user lines
   function automatic logic [DEF_REG_W-1:0] user_field(input int unsigned n);
      logic [DEF_REG_W-1:0] m;
      m = '0;
      for (int unsigned k = 0; k < DEF_REG_W; k++)
         if (k < n) m[k] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int unsigned STAGES      = 2,
   parameter bit          DETECT_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic level_n,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_n};
   end

   assign level_n = chain[STAGES-1];

   if (DETECT_FALL) begin : g_fall
      logic prev_n;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_n <= 1'b1;
         else        prev_n <= level_n;
      end
      assign fall_o = prev_n & ~level_n;

      // R2: one event per transition
      assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
         fall_o |=> !fall_o);
   end else begin : g_level
      assign fall_o = 1'b0;
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned REG_W    = 16,
   parameter int unsigned NUM_USER = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] mask_o
);
   localparam logic [REG_W-1:0] WR_FIELD = REG_W'((64'd1 << NUM_USER) - 64'd1);

   if (NUM_USER >= REG_W) begin : g_bad_width
      $error("irq_mask_reg: NUM_USER must be below REG_W");
   end

   logic [REG_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '0;
      else if (wr_en) mask_q <= wr_data & WR_FIELD;
   end

   assign mask_o = mask_q;

   assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_o == ($past(wr_data) & WR_FIELD)));
   assert_mask_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o & ~WR_FIELD) == '0);
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int unsigned REG_W    = 16,
   parameter int unsigned NUM_USER = 7,
   parameter int unsigned PF_BIT   = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_USER-1:0] set_user,
   input  logic                set_pf,
   input  logic                clr_en,
   input  logic [REG_W-1:0]    clr_data,
   output logic [REG_W-1:0]    pend_o
);
   if (PF_BIT >= REG_W || PF_BIT < NUM_USER) begin : g_bad_pf
      $error("irq_pend_reg: PF_BIT must lie above the user field and inside REG_W");
   end

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i < NUM_USER) begin : g_user
         logic q;
         wire  clr_hit = clr_en & clr_data[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           q <= 1'b0;
            else if (set_user[i]) q <= 1'b1;
            else if (clr_hit)     q <= 1'b0;
         end
         assign pend_o[i] = q;

         // R2 and R7: a detected event always leaves the bit set
         assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set_user[i] |=> pend_o[i]);
         assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && !set_user[i]) |=> !pend_o[i]);
         assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_hit && !set_user[i]) |=> $stable(pend_o[i]));
      end else if (i == PF_BIT) begin : g_pf
         logic q;
         wire  clr_hit = clr_en & clr_data[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= 1'b0;
            else if (set_pf)  q <= 1'b1;
            else if (clr_hit) q <= 1'b0;
         end
         assign pend_o[i] = q;

         assert_pf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_pf |=> pend_o[i]);
      end else begin : g_tie
         wire unused_clr = clr_data[i];
         assign pend_o[i] = 1'b0;

         assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            pend_o[i] == 1'b0);
      end
   end
endmodule

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl
   import irq_pend_pkg::*;
#(
   parameter int unsigned REG_W       = DEF_REG_W,
   parameter int unsigned NUM_USER    = DEF_NUM_USER,
   parameter int unsigned PF_BIT      = DEF_PF_BIT,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_USER-1:0] user_irq_n,
   input  logic                power_fail_n,
   input  logic                mask_wr_en,
   input  logic [REG_W-1:0]    mask_wr_data,
   input  logic                clr_en,
   input  logic [REG_W-1:0]    clr_data,
   output logic [REG_W-1:0]    pending_o,
   output logic [REG_W-1:0]    mask_o,
   output logic                irq_o
);
   localparam logic [REG_W-1:0] PF_ONLY = REG_W'(64'd1 << PF_BIT);

   if (NUM_USER == 0 || NUM_USER > 32) begin : g_bad_users
      $error("irq_pending_ctrl: NUM_USER out of range");
   end

   logic [NUM_USER-1:0] user_fall;
   logic [NUM_USER-1:0] user_lvl_unused;
   logic                pf_lvl_n;
   logic                pf_fall_unused;

   for (genvar l = 0; l < NUM_USER; l++) begin : g_user_sync
      irq_line_sync #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b1)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_n  (user_irq_n[l]),
         .level_n (user_lvl_unused[l]),
         .fall_o  (user_fall[l])
      );
   end

   irq_line_sync #(.STAGES(SYNC_STAGES), .DETECT_FALL(1'b0)) u_pf_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_n  (power_fail_n),
      .level_n (pf_lvl_n),
      .fall_o  (pf_fall_unused)
   );

   irq_mask_reg #(.REG_W(REG_W), .NUM_USER(NUM_USER)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mask_wr_en),
      .wr_data (mask_wr_data),
      .mask_o  (mask_o)
   );

   irq_pend_reg #(.REG_W(REG_W), .NUM_USER(NUM_USER), .PF_BIT(PF_BIT)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_user (user_fall),
      .set_pf   (~pf_lvl_n),
      .clr_en   (clr_en),
      .clr_data (clr_data),
      .pend_o   (pending_o)
   );

   logic [REG_W-1:0] live;
   assign live  = pending_o & (~mask_o | PF_ONLY);
   assign irq_o = |live;

   assert_pf_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o[PF_BIT] |-> irq_o);
   assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pending_o & ~mask_o) != '0) |-> irq_o);
   assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (((pending_o & ~mask_o) == '0) && !pending_o[PF_BIT]) |-> !irq_o);
   assert_pf_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pf_lvl_n |=> pending_o[PF_BIT]);
endmodule

// File: tb/tb_irq_pending_ctrl.sv
module tb_irq_pending_ctrl;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  user_irq_n;
   logic        power_fail_n;
   logic        mask_wr_en;
   logic [15:0] mask_wr_data;
   logic        clr_en;
   logic [15:0] clr_data;
   logic [15:0] pending_o;
   logic [15:0] mask_o;
   logic        irq_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_pending_ctrl dut (
      .clk(clk), .rst_n(rst_n), .user_irq_n(user_irq_n), .power_fail_n(power_fail_n),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .clr_en(clr_en),
      .clr_data(clr_data), .pending_o(pending_o), .mask_o(mask_o), .irq_o(irq_o)
   );

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [6:0] lines);
      user_irq_n = user_irq_n & ~lines;
      tick(3);
      user_irq_n = user_irq_n | lines;
      tick(3);
   endtask

   task automatic clear(input logic [15:0] pat);
      clr_en = 1'b1; clr_data = pat;
      tick(1);
      clr_en = 1'b0; clr_data = '0;
   endtask

   task automatic wr_mask(input logic [15:0] val);
      mask_wr_en = 1'b1; mask_wr_data = val;
      tick(1);
      mask_wr_en = 1'b0; mask_wr_data = '0;
   endtask

   task automatic t_reset;
      chk("R1 pending", pending_o, 16'h0000);
      chk("R1 mask", mask_o, 16'h0000);
      chk("R1 irq", {15'd0, irq_o}, 16'h0000);
   endtask

   task automatic t_user_edges;
      for (int i = 0; i < 7; i++) begin
         user_irq_n[i] = 1'b0;
         tick(2);
         chk("R2 not before third edge", pending_o, 16'h0000);
         tick(1);
         chk("R2 set on fall", pending_o, 16'(1 << i));
         chk("R4 irq unmasked", {15'd0, irq_o}, 16'h0001);
         tick(3);
         clear(16'(1 << i));
         tick(2);
         chk("R2 held low no re-set", pending_o, 16'h0000);
         user_irq_n[i] = 1'b1;
         tick(3);
         chk("R2 rise no set", pending_o, 16'h0000);
      end
   endtask

   task automatic t_mask;
      wr_mask(16'hFFFF);
      chk("R3 writable field", mask_o, 16'h007F);
      pulse(7'b000_1000);
      chk("R3 latch while masked", pending_o, 16'h0008);
      chk("R4 masked no irq", {15'd0, irq_o}, 16'h0000);
      wr_mask(16'h0077);
      chk("R4 unmask raises irq", {15'd0, irq_o}, 16'h0001);
      clear(16'hFFFF);
      wr_mask(16'h0000);
   endtask

   task automatic t_clear_pattern;
      pulse(7'b101_0001);
      chk("R2 several lines", pending_o, 16'h0051);
      clear(16'h0010);
      chk("R6 selective clear", pending_o, 16'h0041);
      clear(16'h7F80);
      chk("R8 upper clear no effect", pending_o, 16'h0041);
      clear(16'hFFFF);
      chk("R6 clear all", pending_o, 16'h0000);
   endtask

   task automatic t_power_fail;
      wr_mask(16'hFFFF);
      power_fail_n = 1'b0;
      tick(3);
      chk("R5 pf sets bit 15", pending_o, 16'h8000);
      chk("R5 irq despite mask", {15'd0, irq_o}, 16'h0001);
      clear(16'h8000);
      chk("R5 clear while low ignored", pending_o, 16'h8000);
      power_fail_n = 1'b1;
      tick(3);
      clear(16'h8000);
      chk("R5 clear after release", pending_o, 16'h0000);
      chk("R5 irq drops", {15'd0, irq_o}, 16'h0000);
      wr_mask(16'h0000);
   endtask

   task automatic t_set_wins;
      pulse(7'b000_0100);
      chk("R7 setup", pending_o, 16'h0004);
      user_irq_n[2] = 1'b0;
      tick(2);
      clr_en = 1'b1; clr_data = 16'h0004;
      tick(1);
      clr_en = 1'b0; clr_data = '0;
      chk("R7 set beats clear", pending_o, 16'h0004);
      user_irq_n[2] = 1'b1;
      tick(3);
      clear(16'h0004);
      chk("R6 clear after race", pending_o, 16'h0000);
   endtask

   task automatic t_master_reset;
      pulse(7'b010_0010);
      wr_mask(16'h000F);
      chk("R9 setup", pending_o, 16'h0022);
      rst_n = 1'b0;
      tick(1);
      rst_n = 1'b1;
      tick(1);
      chk("R9 pending cleared", pending_o, 16'h0000);
      chk("R9 mask cleared", mask_o, 16'h0000);
   endtask

   initial begin
      rst_n = 1'b0; user_irq_n = '1; power_fail_n = 1'b1;
      mask_wr_en = 1'b0; mask_wr_data = '0; clr_en = 1'b0; clr_data = '0;
      @(negedge clk);
      t_reset;
      tick(2);
      rst_n = 1'b1;
      tick(2);
      t_reset;
      t_user_edges;
      t_mask;
      t_clear_pattern;
      t_power_fail;
      t_set_wins;
      t_master_reset;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule